// File: doc/BRIEF.md
# Translation Cache Invalidation Dispatcher

This block sits behind the command queue of an I/O address translation unit. It takes one invalidation command at a time, decodes its opcode, and drives invalidation strobes to the caches that may hold stale state. Those caches are the stream configuration cache, a micro TLB and a main TLB for each client interface, a shared TLB, an intermediate-address (stage-2) cache and a page-walk cache. Each cache sees a strobe, a match-kind code and a shared set of match keys: stream ID, substream ID, ASID, VMID, address and a leaf flag. It answers with a one-cycle done pulse. The strobe to a cache stays raised until that cache acknowledges it.

A stream-ID range command either clears everything or is expanded into an ascending run of single-ID steps. The run starts at an aligned base ID and each step waits for all of its acknowledges. Leaf-only address commands spare the walk cache. Prefetch hints complete at once with no strobe. An opcode the block does not recognise also completes at once, and it sets a sticky flag.

Top module: `inval_dispatch`

## Requirements
- R1: `cmd_ready` is the inverse of `busy`, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Strobes and keys for the command appear in the cycle after it is taken. `busy` stays high until the cycle after the edge that takes the last acknowledge, and no command is taken while `busy` is high.
- R2: A strobe stays high until its own done input is high on a clock edge while the strobe is high. It is low in the following cycle unless a new range step begins. A done input on a cache whose strobe is low has no effect.
- R3: Opcodes 0x01 and 0x02 (prefetch hints) raise no strobe and leave `busy` low.
- R4: Opcode 0x03 strobes the config cache and every micro and main TLB with kind SID (1), with `key_sid` equal to the command's stream ID.
- R5: Opcode 0x04 with range value 31 strobes the config cache and every micro and main TLB once, with kind ALL (0).
- R6: Opcode 0x04 with any other range value r issues 2^min(r+1, SID_W) single-ID steps of kind SID (1) to the config cache and all micro and main TLBs. The first step uses the stream ID with its low min(r+1, SID_W) bits cleared, and each later step uses the previous ID plus one. Each step starts in the cycle after the edge that takes the last acknowledge of the step before it.
- R7: Opcode 0x05 strobes the config cache and all micro and main TLBs with kind SSID (2). Opcode 0x06 strobes the same caches with kind SID (1).
- R8: Opcodes 0x13 (kind VA, 5) and 0x12 (kind VAA, 6) strobe all micro, main and shared TLBs. They strobe the walk cache with the same kind only when `cmd_leaf` is 0.
- R9: Opcode 0x20 strobes only the IPA cache with kind IPA (7), plus the walk cache with kind VMID (3) when `cmd_leaf` is 0.
- R10: Opcode 0x21 strobes all micro, main and shared TLBs, the IPA cache and the walk cache with kind VMID (3). Opcode 0x30 strobes the same caches with kind ALL (0).
- R11: Opcode 0x11 (kind ASID, 4) and opcode 0x10 (kind VMID, 3) strobe all micro, main and shared TLBs and the walk cache, and never the IPA cache.
- R12: Any other opcode raises no strobe and leaves `busy` low. It sets `unsup_flag` in the cycle after the command is taken, and the flag then stays high until reset.
- R13: After reset all strobes, `busy` and `unsup_flag` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 8 | Command opcode |
| cmd_sid | input | SID_W | Stream ID |
| cmd_ssid | input | SSID_W | Substream ID |
| cmd_asid | input | ASID_W | Address-space ID |
| cmd_vmid | input | VMID_W | Virtual machine ID |
| cmd_addr | input | ADDR_W | Virtual or intermediate address |
| cmd_leaf | input | 1 | Leaf-only flag |
| cmd_range | input | 5 | Range exponent for stream-ID range command |
| busy | output | 1 | Command in progress |
| unsup_flag | output | 1 | Sticky unknown-opcode flag |
| key_sid | output | SID_W | Match key: stream ID of current step |
| key_ssid | output | SSID_W | Match key: substream ID |
| key_asid | output | ASID_W | Match key: ASID |
| key_vmid | output | VMID_W | Match key: VMID |
| key_addr | output | ADDR_W | Match key: address |
| key_leaf | output | 1 | Match key: leaf flag |
| cfg_kind | output | 3 | Match kind for config cache |
| tlb_kind | output | 3 | Match kind for micro, main and shared TLBs |
| ipa_kind | output | 3 | Match kind for IPA cache |
| walk_kind | output | 3 | Match kind for walk cache |
| cfg_stb | output | 1 | Config cache strobe |
| cfg_done | input | 1 | Config cache acknowledge |
| utlb_stb | output | NUM_IFC | Micro TLB strobes, one per interface |
| utlb_done | input | NUM_IFC | Micro TLB acknowledges |
| mtlb_stb | output | NUM_IFC | Main TLB strobes, one per interface |
| mtlb_done | input | NUM_IFC | Main TLB acknowledges |
| tlb_stb | output | 1 | Shared TLB strobe |
| tlb_done | input | 1 | Shared TLB acknowledge |
| ipa_stb | output | 1 | IPA cache strobe |
| ipa_done | input | 1 | IPA cache acknowledge |
| walk_stb | output | 1 | Walk cache strobe |
| walk_done | input | 1 | Walk cache acknowledge |

## Verification
Strobes, kinds and keys are due one cycle after the edge that takes a command. Each strobe falls one cycle after the edge that samples its acknowledge. A range step's strobes and its incremented `key_sid` come back one cycle after the edge that takes the step's final acknowledge. `busy` falls one cycle after the last acknowledge, and `unsup_flag` rises one cycle after an unknown opcode is taken. The bench drives inputs on falling edges and compares on the next falling edge against its own model of outstanding acknowledges. The model is updated with the same random done pattern it drives, so every cycle is checked at the point where the registered outputs have settled.

// File: rtl/inval_pkg.sv
package inval_pkg;
  localparam int OP_W    = 8;
  localparam int RANGE_W = 5;
  localparam logic [RANGE_W-1:0] RANGE_ALL = 5'd31;

  localparam logic [OP_W-1:0] OP_PF_CFG      = 8'h01;
  localparam logic [OP_W-1:0] OP_PF_ADDR     = 8'h02;
  localparam logic [OP_W-1:0] OP_CFG_SID     = 8'h03;
  localparam logic [OP_W-1:0] OP_CFG_RANGE   = 8'h04;
  localparam logic [OP_W-1:0] OP_CFG_CTX     = 8'h05;
  localparam logic [OP_W-1:0] OP_CFG_CTX_ALL = 8'h06;
  localparam logic [OP_W-1:0] OP_TLB_VMID    = 8'h10;
  localparam logic [OP_W-1:0] OP_TLB_ASID    = 8'h11;
  localparam logic [OP_W-1:0] OP_TLB_VAA     = 8'h12;
  localparam logic [OP_W-1:0] OP_TLB_VA      = 8'h13;
  localparam logic [OP_W-1:0] OP_IPA_S2      = 8'h20;
  localparam logic [OP_W-1:0] OP_VM_ALL      = 8'h21;
  localparam logic [OP_W-1:0] OP_GLOBAL_ALL  = 8'h30;

  typedef enum logic [2:0] {
    K_ALL  = 3'd0,
    K_SID  = 3'd1,
    K_SSID = 3'd2,
    K_VMID = 3'd3,
    K_ASID = 3'd4,
    K_VA   = 3'd5,
    K_VAA  = 3'd6,
    K_IPA  = 3'd7
  } kind_e;

  // ifc covers the micro and main TLBs of every client interface
  typedef struct packed {
    logic cfg;
    logic ifc;
    logic tlb;
    logic ipa;
    logic walk;
  } tgt_t;
endpackage

// File: rtl/inval_decode.sv
module inval_decode
  import inval_pkg::*;
(
  input  logic [OP_W-1:0]    op,
  input  logic               leaf,
  input  logic [RANGE_W-1:0] rng,
  output tgt_t               tgt,
  output kind_e              cfg_kind,
  output kind_e              tlbs_kind,
  output kind_e              ipa_kind,
  output kind_e              walk_kind,
  output logic               expand,
  output logic               unknown
);
  always_comb begin
    tgt       = '0;
    cfg_kind  = K_ALL;
    tlbs_kind = K_ALL;
    ipa_kind  = K_ALL;
    walk_kind = K_ALL;
    expand    = 1'b0;
    unknown   = 1'b0;
    case (op)
      OP_PF_CFG, OP_PF_ADDR: begin
      end
      OP_CFG_SID, OP_CFG_CTX_ALL: begin
        tgt.cfg   = 1'b1;
        tgt.ifc   = 1'b1;
        cfg_kind  = K_SID;
        tlbs_kind = K_SID;
      end
      OP_CFG_RANGE: begin
        tgt.cfg = 1'b1;
        tgt.ifc = 1'b1;
        if (rng != RANGE_ALL) begin
          cfg_kind  = K_SID;
          tlbs_kind = K_SID;
          expand    = 1'b1;
        end
      end
      OP_CFG_CTX: begin
        tgt.cfg   = 1'b1;
        tgt.ifc   = 1'b1;
        cfg_kind  = K_SSID;
        tlbs_kind = K_SSID;
      end
      OP_TLB_VMID: begin
        tgt.ifc   = 1'b1;
        tgt.tlb   = 1'b1;
        tgt.walk  = 1'b1;
        tlbs_kind = K_VMID;
        walk_kind = K_VMID;
      end
      OP_TLB_ASID: begin
        tgt.ifc   = 1'b1;
        tgt.tlb   = 1'b1;
        tgt.walk  = 1'b1;
        tlbs_kind = K_ASID;
        walk_kind = K_ASID;
      end
      OP_TLB_VAA: begin
        tgt.ifc   = 1'b1;
        tgt.tlb   = 1'b1;
        tgt.walk  = !leaf;
        tlbs_kind = K_VAA;
        walk_kind = K_VAA;
      end
      OP_TLB_VA: begin
        tgt.ifc   = 1'b1;
        tgt.tlb   = 1'b1;
        tgt.walk  = !leaf;
        tlbs_kind = K_VA;
        walk_kind = K_VA;
      end
      OP_IPA_S2: begin
        tgt.ipa   = 1'b1;
        tgt.walk  = !leaf;
        ipa_kind  = K_IPA;
        walk_kind = K_VMID;
      end
      OP_VM_ALL: begin
        tgt.ifc   = 1'b1;
        tgt.tlb   = 1'b1;
        tgt.ipa   = 1'b1;
        tgt.walk  = 1'b1;
        tlbs_kind = K_VMID;
        ipa_kind  = K_VMID;
        walk_kind = K_VMID;
      end
      OP_GLOBAL_ALL: begin
        tgt.ifc  = 1'b1;
        tgt.tlb  = 1'b1;
        tgt.ipa  = 1'b1;
        tgt.walk = 1'b1;
      end
      default: unknown = 1'b1;
    endcase
  end
endmodule

// File: rtl/inval_range_seq.sv
module inval_range_seq
  import inval_pkg::*;
#(
  parameter int SID_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               expand,
  input  logic [RANGE_W-1:0] rng,
  input  logic [SID_W-1:0]   sid,
  input  logic               advance,
  output logic [SID_W-1:0]   cur_sid,
  output logic               last
);
  localparam logic [SID_W:0]   ONE_W   = 1;
  localparam logic [SID_W-1:0] SID_ONE = 1;

  logic [SID_W:0]   span_w;
  logic [SID_W-1:0] span_m1;
  logic [SID_W-1:0] remain;
  int               sh;

  // number of extra steps = 2^min(rng+1, SID_W) - 1, also the alignment mask
  always_comb begin
    sh = int'(rng) + 1;
    if (sh > SID_W) sh = SID_W;
    span_w  = (ONE_W << sh) - ONE_W;
    span_m1 = span_w[SID_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_sid <= '0;
      remain  <= '0;
    end else if (load) begin
      if (expand) begin
        cur_sid <= sid & ~span_m1;
        remain  <= span_m1;
      end else begin
        cur_sid <= sid;
        remain  <= '0;
      end
    end else if (advance && (remain != '0)) begin
      cur_sid <= cur_sid + SID_ONE;
      remain  <= remain - SID_ONE;
    end
  end

  assign last = (remain == '0);
endmodule

// File: rtl/inval_pending.sv
module inval_pending #(
  parameter int NPEND = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NPEND-1:0] load_vec,
  input  logic [NPEND-1:0] done,
  output logic [NPEND-1:0] pend,
  output logic             step_done
);
  for (genvar i = 0; i < NPEND; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst)          q <= 1'b0;
      else if (load)    q <= load_vec[i];
      else if (done[i]) q <= 1'b0;
    end
    assign pend[i] = q;
  end

  // every outstanding strobe is acknowledged on this edge
  assign step_done = (|pend) && ((pend & ~done) == '0);
endmodule

// File: rtl/inval_dispatch.sv
module inval_dispatch
  import inval_pkg::*;
#(
  parameter int NUM_IFC = 2,
  parameter int SID_W   = 8,
  parameter int SSID_W  = 8,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 16,
  parameter int ADDR_W  = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_op,
  input  logic [SID_W-1:0]     cmd_sid,
  input  logic [SSID_W-1:0]    cmd_ssid,
  input  logic [ASID_W-1:0]    cmd_asid,
  input  logic [VMID_W-1:0]    cmd_vmid,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic                 cmd_leaf,
  input  logic [4:0]           cmd_range,
  output logic                 busy,
  output logic                 unsup_flag,
  output logic [SID_W-1:0]     key_sid,
  output logic [SSID_W-1:0]    key_ssid,
  output logic [ASID_W-1:0]    key_asid,
  output logic [VMID_W-1:0]    key_vmid,
  output logic [ADDR_W-1:0]    key_addr,
  output logic                 key_leaf,
  output logic [2:0]           cfg_kind,
  output logic [2:0]           tlb_kind,
  output logic [2:0]           ipa_kind,
  output logic [2:0]           walk_kind,
  output logic                 cfg_stb,
  input  logic                 cfg_done,
  output logic [NUM_IFC-1:0]   utlb_stb,
  input  logic [NUM_IFC-1:0]   utlb_done,
  output logic [NUM_IFC-1:0]   mtlb_stb,
  input  logic [NUM_IFC-1:0]   mtlb_done,
  output logic                 tlb_stb,
  input  logic                 tlb_done,
  output logic                 ipa_stb,
  input  logic                 ipa_done,
  output logic                 walk_stb,
  input  logic                 walk_done
);
  // pending vector layout: {main TLBs, micro TLBs, walk, ipa, shared tlb, cfg}
  localparam int NPEND = 4 + 2 * NUM_IFC;
  localparam logic [NPEND-1:0] RANGE_VEC = {{(2*NUM_IFC){1'b1}}, 4'b0001};

  tgt_t             dec_tgt;
  kind_e            dec_cfg_k, dec_tlbs_k, dec_ipa_k, dec_walk_k;
  logic             dec_expand, dec_unknown;
  logic             busy_q, accept, reload, load, step_done, seq_last;
  logic [NPEND-1:0] acc_vec, load_vec, done_vec, pend;

  inval_decode u_dec (
    .op        (cmd_op),
    .leaf      (cmd_leaf),
    .rng       (cmd_range),
    .tgt       (dec_tgt),
    .cfg_kind  (dec_cfg_k),
    .tlbs_kind (dec_tlbs_k),
    .ipa_kind  (dec_ipa_k),
    .walk_kind (dec_walk_k),
    .expand    (dec_expand),
    .unknown   (dec_unknown)
  );

  assign accept   = cmd_valid && !busy_q;
  assign acc_vec  = {{(2*NUM_IFC){dec_tgt.ifc}}, dec_tgt.walk, dec_tgt.ipa,
                     dec_tgt.tlb, dec_tgt.cfg};
  assign reload   = step_done && !seq_last;
  assign load     = accept || reload;
  assign load_vec = accept ? acc_vec : RANGE_VEC;
  assign done_vec = {mtlb_done, utlb_done, walk_done, ipa_done, tlb_done, cfg_done};

  inval_pending #(.NPEND(NPEND)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_vec  (load_vec),
    .done      (done_vec),
    .pend      (pend),
    .step_done (step_done)
  );

  inval_range_seq #(.SID_W(SID_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .expand  (dec_expand),
    .rng     (cmd_range),
    .sid     (cmd_sid),
    .advance (reload),
    .cur_sid (key_sid),
    .last    (seq_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      unsup_flag <= 1'b0;
      key_ssid   <= '0;
      key_asid   <= '0;
      key_vmid   <= '0;
      key_addr   <= '0;
      key_leaf   <= 1'b0;
      cfg_kind   <= K_ALL;
      tlb_kind   <= K_ALL;
      ipa_kind   <= K_ALL;
      walk_kind  <= K_ALL;
    end else begin
      if (accept) begin
        busy_q    <= |acc_vec;
        key_ssid  <= cmd_ssid;
        key_asid  <= cmd_asid;
        key_vmid  <= cmd_vmid;
        key_addr  <= cmd_addr;
        key_leaf  <= cmd_leaf;
        cfg_kind  <= dec_cfg_k;
        tlb_kind  <= dec_tlbs_k;
        ipa_kind  <= dec_ipa_k;
        walk_kind <= dec_walk_k;
        if (dec_unknown) unsup_flag <= 1'b1;
      end else if (step_done && seq_last) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign cmd_ready = !busy_q;
  assign cfg_stb   = pend[0];
  assign tlb_stb   = pend[1];
  assign ipa_stb   = pend[2];
  assign walk_stb  = pend[3];
  assign utlb_stb  = pend[4 +: NUM_IFC];
  assign mtlb_stb  = pend[4+NUM_IFC +: NUM_IFC];
endmodule

// File: rtl/inval_dispatch_checker.sv
module inval_dispatch_checker
  import inval_pkg::*;
#(
  parameter int SID_W  = 8,
  parameter int ASID_W = 16,
  parameter int VMID_W = 16,
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              unsup_flag,
  input logic [SID_W-1:0]  key_sid,
  input logic [ASID_W-1:0] key_asid,
  input logic [VMID_W-1:0] key_vmid,
  input logic [ADDR_W-1:0] key_addr,
  input logic              key_leaf,
  input logic [2:0]        ipa_kind,
  input logic [2:0]        walk_kind,
  input logic              cfg_stb,
  input logic              cfg_done,
  input logic              tlb_stb,
  input logic              tlb_done,
  input logic              ipa_stb,
  input logic              walk_stb
);
  localparam logic [SID_W-1:0] SID_ONE = 1;

  assert_keys_hold_R1: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(key_vmid) && $stable(key_asid) && $stable(key_addr)));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_stb && !cfg_done) |=> cfg_stb);

  assert_tlb_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (tlb_stb && !tlb_done) |=> tlb_stb);

  assert_tlb_release_R2: assert property (@(posedge clk) disable iff (rst)
    (tlb_stb && tlb_done) |=> !tlb_stb);

  assert_range_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_stb && cfg_done) |=> (!cfg_stb || (key_sid == $past(key_sid) + SID_ONE)));

  assert_leaf_walk_R8: assert property (@(posedge clk) disable iff (rst)
    (walk_stb && (walk_kind == K_VA || walk_kind == K_VAA)) |-> !key_leaf);

  assert_ipa_kind_R9: assert property (@(posedge clk) disable iff (rst)
    ipa_stb |-> (ipa_kind == K_IPA || ipa_kind == K_VMID || ipa_kind == K_ALL));

  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    unsup_flag |=> unsup_flag);
endmodule

bind inval_dispatch inval_dispatch_checker #(
  .SID_W(SID_W), .ASID_W(ASID_W), .VMID_W(VMID_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .unsup_flag (unsup_flag),
  .key_sid    (key_sid),
  .key_asid   (key_asid),
  .key_vmid   (key_vmid),
  .key_addr   (key_addr),
  .key_leaf   (key_leaf),
  .ipa_kind   (ipa_kind),
  .walk_kind  (walk_kind),
  .cfg_stb    (cfg_stb),
  .cfg_done   (cfg_done),
  .tlb_stb    (tlb_stb),
  .tlb_done   (tlb_done),
  .ipa_stb    (ipa_stb),
  .walk_stb   (walk_stb)
);

// File: tb/inval_dispatch_tb.sv
module inval_dispatch_tb;
  localparam int NUM_IFC = 2, SID_W = 8, SSID_W = 8, ASID_W = 16, VMID_W = 16, ADDR_W = 48;
  localparam int NP = 4 + 2 * NUM_IFC;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready, cmd_leaf = 1'b0;
  logic [7:0] cmd_op = '0;
  logic [SID_W-1:0] cmd_sid = '0;
  logic [SSID_W-1:0] cmd_ssid = '0;
  logic [ASID_W-1:0] cmd_asid = '0;
  logic [VMID_W-1:0] cmd_vmid = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [4:0] cmd_range = '0;
  logic busy, unsup_flag, key_leaf;
  logic [SID_W-1:0] key_sid;
  logic [SSID_W-1:0] key_ssid;
  logic [ASID_W-1:0] key_asid;
  logic [VMID_W-1:0] key_vmid;
  logic [ADDR_W-1:0] key_addr;
  logic [2:0] cfg_kind, tlb_kind, ipa_kind, walk_kind;
  logic cfg_stb, tlb_stb, ipa_stb, walk_stb;
  logic cfg_done, tlb_done, ipa_done, walk_done;
  logic [NUM_IFC-1:0] utlb_stb, mtlb_stb, utlb_done, mtlb_done;
  logic [NP-1:0] stb_v, done_v = '0;

  assign stb_v = {mtlb_stb, utlb_stb, walk_stb, ipa_stb, tlb_stb, cfg_stb};
  assign {mtlb_done, utlb_done, walk_done, ipa_done, tlb_done, cfg_done} = done_v;

  always #2 clk = ~clk;

  inval_dispatch #(.NUM_IFC(NUM_IFC), .SID_W(SID_W), .SSID_W(SSID_W), .ASID_W(ASID_W),
                   .VMID_W(VMID_W), .ADDR_W(ADDR_W)) u_dut (.*);

  int checks = 0, fails = 0;
  bit exp_unsup = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] tvec(bit c, bit ifc, bit t, bit ip, bit w);
    return {{(2*NUM_IFC){ifc}}, w, ip, t, c};
  endfunction

  // expected behaviour from the requirements; kinds: ALL0 SID1 SSID2 VMID3 ASID4 VA5 VAA6 IPA7
  function automatic void model(input logic [7:0] op, input bit leaf, input logic [4:0] rng,
      output logic [NP-1:0] v, output logic [2:0] kc, output logic [2:0] kt,
      output logic [2:0] ki, output logic [2:0] kw, output bit expand,
      output bit unk, output string rq);
    v = '0; kc = 0; kt = 0; ki = 0; kw = 0; expand = 0; unk = 0;
    case (op)
      8'h01, 8'h02: rq = "R3";
      8'h03: begin v = tvec(1,1,0,0,0); kc = 1; kt = 1; rq = "R4"; end
      8'h04: begin
        v = tvec(1,1,0,0,0);
        if (rng == 5'd31) rq = "R5";
        else begin kc = 1; kt = 1; expand = 1; rq = "R6"; end
      end
      8'h05: begin v = tvec(1,1,0,0,0); kc = 2; kt = 2; rq = "R7"; end
      8'h06: begin v = tvec(1,1,0,0,0); kc = 1; kt = 1; rq = "R7"; end
      8'h10: begin v = tvec(0,1,1,0,1); kt = 3; kw = 3; rq = "R11"; end
      8'h11: begin v = tvec(0,1,1,0,1); kt = 4; kw = 4; rq = "R11"; end
      8'h12: begin v = tvec(0,1,1,0,!leaf); kt = 6; kw = 6; rq = "R8"; end
      8'h13: begin v = tvec(0,1,1,0,!leaf); kt = 5; kw = 5; rq = "R8"; end
      8'h20: begin v = tvec(0,0,0,1,!leaf); ki = 7; kw = 3; rq = "R9"; end
      8'h21: begin v = tvec(0,1,1,1,1); kt = 3; ki = 3; kw = 3; rq = "R10"; end
      8'h30: begin v = tvec(0,1,1,1,1); rq = "R10"; end
      default: begin unk = 1; rq = "R12"; end
    endcase
  endfunction

  task automatic do_cmd(input logic [7:0] op, input logic [SID_W-1:0] sid,
                        input logic [SSID_W-1:0] ssid, input logic [ASID_W-1:0] asid,
                        input logic [VMID_W-1:0] vmid, input logic [ADDR_W-1:0] addr,
                        input bit leaf, input logic [4:0] rng);
    logic [NP-1:0] mp, mp_n, dv;
    logic [2:0] kc, kt, ki, kw;
    bit expand, unk;
    string rq;
    int steps_left, sh, guard;
    logic [SID_W-1:0] esid;
    model(op, leaf, rng, mp, kc, kt, ki, kw, expand, unk, rq);
    chk(cmd_ready == 1'b1, "R1", "ready before command", {63'd0, cmd_ready}, 64'd1);
    cmd_op = op; cmd_sid = sid; cmd_ssid = ssid; cmd_asid = asid; cmd_vmid = vmid;
    cmd_addr = addr; cmd_leaf = leaf; cmd_range = rng; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op = 8'h30; cmd_vmid = ~vmid; cmd_addr = ~addr; cmd_asid = ~asid;
    if (unk) exp_unsup = 1;
    chk(unsup_flag == exp_unsup, "R12", "unsupported flag", {63'd0, unsup_flag}, {63'd0, exp_unsup});
    steps_left = 0; esid = sid;
    if (expand) begin
      sh = int'(rng) + 1;
      if (sh > SID_W) sh = SID_W;
      steps_left = (1 << sh) - 1;
      esid = sid & ~SID_W'((1 << sh) - 1);
    end
    if (mp == '0) begin
      chk(busy == 1'b0 && stb_v == '0, rq, "no strobe and idle", {55'd0, busy, stb_v}, 64'd0);
      return;
    end
    if (mp[0]) chk(cfg_kind == kc, rq, "cfg kind", 64'(cfg_kind), 64'(kc));
    if (mp[1]) chk(tlb_kind == kt, rq, "tlb kind", 64'(tlb_kind), 64'(kt));
    if (mp[2]) chk(ipa_kind == ki, rq, "ipa kind", 64'(ipa_kind), 64'(ki));
    if (mp[3]) chk(walk_kind == kw, rq, "walk kind", 64'(walk_kind), 64'(kw));
    chk(key_ssid == ssid && key_leaf == leaf, rq, "ssid/leaf keys", 64'(key_ssid), 64'(ssid));
    guard = 0;
    while (mp != '0 && guard < 20000) begin
      chk(stb_v == mp, "R2", "strobe vector", 64'(stb_v), 64'(mp));
      chk(busy == 1'b1 && cmd_ready == 1'b0, "R1", "busy while pending", {63'd0, busy}, 64'd1);
      chk(key_sid == esid, rq, "stream key", 64'(key_sid), 64'(esid));
      chk(key_vmid == vmid && key_asid == asid && key_addr == addr, "R1", "keys held",
          64'(key_addr), 64'(addr));
      dv = NP'($urandom);
      done_v = dv;
      mp_n = mp & ~dv;
      if (mp_n == '0 && steps_left > 0) begin
        mp_n = tvec(1,1,0,0,0);
        steps_left--;
        esid = esid + 1'b1;
      end
      cmd_valid = (mp_n != '0) ? 1'($urandom) : 1'b0;
      mp = mp_n;
      @(negedge clk);
      guard++;
    end
    done_v = '0;
    cmd_valid = 1'b0;
    chk(busy == 1'b0 && stb_v == '0 && cmd_ready == 1'b1, "R1", "idle after last ack",
        {55'd0, busy, stb_v}, 64'd0);
    chk(key_vmid == vmid && key_addr == addr, "R1", "no command taken while busy",
        64'(key_vmid), 64'(vmid));
  endtask

  task automatic rnd_cmd(input logic [7:0] op, input bit leaf, input logic [4:0] rng);
    do_cmd(op, SID_W'($urandom), SSID_W'($urandom), ASID_W'($urandom), VMID_W'($urandom),
           {16'($urandom), 32'($urandom)}, leaf, rng);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [14];
    int seed;
    seed = $urandom(32'd20251);
    ops = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h10, 8'h11, 8'h12, 8'h13,
            8'h20, 8'h21, 8'h30, 8'h44};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk(busy == 0 && stb_v == '0 && cmd_ready == 1 && unsup_flag == 0, "R13", "reset state",
        {54'd0, busy, unsup_flag, stb_v}, 64'd0);
    // stray acknowledges while idle must not create a strobe (R2)
    done_v = '1;
    @(negedge clk);
    done_v = '0;
    chk(stb_v == '0 && busy == 0, "R2", "stray done while idle", 64'(stb_v), 64'd0);
    // directed cases
    rnd_cmd(8'h01, 0, 0);                                       // R3
    rnd_cmd(8'h02, 1, 3);                                       // R3
    do_cmd(8'h03, 8'h5A, 1, 2, 3, 48'h1000, 0, 0);              // R4
    do_cmd(8'h04, 8'h77, 0, 0, 0, 48'h0, 0, 5'd31);             // R5
    do_cmd(8'h04, 8'h77, 0, 0, 0, 48'h0, 0, 5'd0);              // R6 two IDs from 0x76
    do_cmd(8'h04, 8'h2F, 0, 0, 0, 48'h0, 0, 5'd2);              // R6 eight IDs from 0x28
    do_cmd(8'h04, 8'hC3, 0, 0, 0, 48'h0, 0, 5'd7);              // R6 full space
    do_cmd(8'h04, 8'h11, 0, 0, 0, 48'h0, 0, 5'd20);             // R6 capped at SID_W
    do_cmd(8'h05, 8'h09, 8'h33, 0, 0, 48'h0, 0, 0);             // R7
    do_cmd(8'h06, 8'h09, 8'h33, 0, 0, 48'h0, 1, 0);             // R7
    do_cmd(8'h13, 0, 0, 16'hAB, 16'h7, 48'hABC000, 0, 0);       // R8 walk included
    do_cmd(8'h13, 0, 0, 16'hAB, 16'h7, 48'hABC000, 1, 0);       // R8 leaf spares walk
    do_cmd(8'h12, 0, 0, 16'h0, 16'h9, 48'h123000, 1, 0);        // R8
    do_cmd(8'h20, 0, 0, 0, 16'h4, 48'h8000, 0, 0);              // R9 walk by VMID
    do_cmd(8'h20, 0, 0, 0, 16'h4, 48'h8000, 1, 0);              // R9 IPA only
    do_cmd(8'h21, 0, 0, 0, 16'h2, 48'h0, 0, 0);                 // R10
    do_cmd(8'h30, 0, 0, 0, 0, 48'h0, 0, 0);                     // R10
    do_cmd(8'h11, 0, 0, 16'h55, 16'h2, 48'h0, 0, 0);            // R11
    do_cmd(8'h10, 0, 0, 0, 16'h3, 48'h0, 0, 0);                 // R11
    chk(unsup_flag == 0, "R12", "flag clear before unknown opcode", {63'd0, unsup_flag}, 64'd0);
    rnd_cmd(8'h7F, 0, 0);                                       // R12
    rnd_cmd(8'h03, 0, 0);                                       // R12 stays set
    // constrained random mix
    for (int i = 0; i < 150; i++) begin
      logic [4:0] r;
      r = ($urandom % 8 == 0) ? 5'd31 : 5'(($urandom % 5));
      rnd_cmd(ops[$urandom % 14], 1'($urandom), r);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule